// File: doc/BRIEF.md
# Shift-Multiply ALU with Condition Flags

This block is the arithmetic slice of a small RISC integer core. On each cycle where `valid_i` is high it takes a 3-bit operation selector and two 32-bit operands. It computes one of eight operations: add, subtract, logical right shift, logical left shift, arithmetic right shift, rotate left, unsigned 16x16 multiply or signed 16x16 multiply. On the next clock edge it registers the 32-bit result together with a 4-bit condition code.

For every shift and rotate, the first operand is the value and the second operand is the amount. Shift amounts at or beyond the word width saturate rather than wrap, so software can shift a value all the way out. Shifts report the last bit that left the word in the carry flag. Logical shifts raise overflow whenever the sign bit changes, which lets a following conditional branch detect a lost sign. The multiplies read only the low half of each operand, so a single narrow multiplier serves both signed and unsigned forms.

An asynchronous active-low reset clears all outputs. Reset release is synchronised internally over two flops.

Top module: `alu_flags_core`

## Requirements
- R1: Operation encoding on `op_i`: 0 add, 1 subtract, 2 logical right shift, 3 logical left shift, 4 arithmetic right shift, 5 rotate left, 6 unsigned multiply, 7 signed multiply. Result and flags appear on the clock edge after the one that sampled `valid_i` high. `res_vld_o` is high for exactly that one cycle per accepted operation. Outputs hold their values while `valid_i` is low.
- R2: Flag positions in `flags_o` are zero = bit 0, carry = bit 1, negative = bit 2 and overflow = bit 3. For every operation, zero means the 32-bit result equals 0 and negative equals result bit 31.
- R3: Add returns A+B modulo 2^32. Carry is the unsigned carry out, and overflow is set when both operands share a sign that the result lacks (0x7FFFFFFF+1 sets overflow; 0xFFFFFFFF+1 sets carry and zero).
- R4: Subtract returns A−B modulo 2^32. Carry is a borrow, set when A < B unsigned (0−1 sets carry). Overflow marks a signed overflow (0x80000000−1 sets overflow).
- R5: Any shift or rotate by an amount of 0 returns A unchanged with carry and overflow clear.
- R6: A logical right shift by 1..31 fills with zeros, and carry is the last bit shifted out. A shift by 32 gives 0 with carry = A bit 31. A shift by more than 32 gives 0 with carry 0.
- R7: A logical left shift by 1..31 fills with zeros, and carry is the last bit shifted out (A bit 32−amount). A shift by 32 gives 0 with carry = A bit 0. A shift by more than 32 gives 0 with carry 0.
- R8: An arithmetic right shift fills with A bit 31, and carry is the last bit shifted out. An amount of 32 or more gives 32 copies of A bit 31 with carry = A bit 31. Overflow is never set.
- R9: Both logical shifts set overflow exactly when result bit 31 differs from A bit 31.
- R10: Rotate left uses the amount modulo 32, and clears carry and overflow.
- R11: Unsigned multiply returns the 32-bit product of A[15:0] and B[15:0] (0xFFFF·0xFFFF = 0xFFFE0001). Operand bits 31:16 are ignored. Carry and overflow are clear.
- R12: Signed multiply treats A[15:0] and B[15:0] as two's complement and returns their 32-bit product (0x8000·0x8000 = 0x40000000; 0x8001·0x7FFF = 0xC000FFFF). Operand bits 31:16 are ignored. Carry and overflow are clear.
- R13: While reset is asserted, `result_o`, `flags_o` and `res_vld_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation selector |
| a_i | input | 32 | Operand A (value) |
| b_i | input | 32 | Operand B (second operand or shift amount) |
| res_vld_o | output | 1 | Result strobe, one cycle per accepted operation |
| result_o | output | 32 | Registered result |
| flags_o | output | 4 | Registered condition code {V,N,C,Z} |

## Verification
The checker is disabled on the internally synchronised reset. It therefore assumes `valid_i` is not raised until that synchronised reset has released, two clocks after `rst_n` rises. The bench waits several clocks after release before its first operation. The properties also assume `op_i`, `a_i` and `b_i` are only meaningful in a cycle where `valid_i` is high. The bench changes operands only on falling edges and drops `valid_i` between scenarios, so every `$past` reference sees the operation that was actually accepted.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_LSR  = 3'd2,
    OP_LSL  = 3'd3,
    OP_ASR  = 3'd4,
    OP_ROL  = 3'd5,
    OP_MPYU = 3'd6,
    OP_MPYS = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSR = 2'd0,
    SH_LSL = 2'd1,
    SH_ASR = 2'd2,
    SH_ROL = 2'd3
  } shift_kind_e;

  localparam int FLG_Z = 0;
  localparam int FLG_C = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_W = 4;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);

  logic [WIDTH-1:0] b_eff;
  logic             c_out;

  always_comb begin
    b_eff          = sub ? ~b : b;
    {c_out, sum}   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    // on subtract the carry out is inverted into a borrow
    carry          = sub ? ~c_out : c_out;
    ovf            = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] amt,
  input  shift_kind_e      kind,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);

  localparam int SAT_W = $clog2(WIDTH + 2);
  localparam int ROT_W = $clog2(WIDTH);

  logic [SAT_W-1:0]        amt_sat;
  logic [ROT_W-1:0]        rot;
  logic [WIDTH:0]          ext_r;
  logic signed [WIDTH:0]   ext_a;
  logic [WIDTH:0]          ext_l;

  // one guard bit below (right shifts) or above (left shift) captures carry
  always_comb begin
    amt_sat = (amt > WIDTH) ? SAT_W'(WIDTH + 1) : amt[SAT_W-1:0];
    rot     = amt[ROT_W-1:0];
    ext_r   = {a, 1'b0} >> amt_sat;
    ext_a   = $signed({a, 1'b0}) >>> amt_sat;
    ext_l   = {1'b0, a} << amt_sat;
    res     = a;
    carry   = 1'b0;
    ovf     = 1'b0;
    case (kind)
      SH_LSR: begin
        res   = ext_r[WIDTH:1];
        carry = ext_r[0];
        ovf   = res[WIDTH-1] != a[WIDTH-1];
      end
      SH_LSL: begin
        res   = ext_l[WIDTH-1:0];
        carry = ext_l[WIDTH];
        ovf   = res[WIDTH-1] != a[WIDTH-1];
      end
      SH_ASR: begin
        res   = ext_a[WIDTH:1];
        carry = ext_a[0];
      end
      default: begin
        res = (a << rot) | (a >> (WIDTH - int'(rot)));
      end
    endcase
  end

endmodule

// File: rtl/alu_multiplier.sv
module alu_multiplier #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH/2-1:0] a_lo,
  input  logic [WIDTH/2-1:0] b_lo,
  input  logic               signed_mode,
  output logic [WIDTH-1:0]   prod
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] a_ext;
  logic [WIDTH-1:0] b_ext;

  // sign or zero extension feeds one shared multiplier; low WIDTH bits are exact
  always_comb begin
    a_ext = {{HALF{signed_mode & a_lo[HALF-1]}}, a_lo};
    b_ext = {{HALF{signed_mode & b_lo[HALF-1]}}, b_lo};
    prod  = a_ext * b_ext;
  end

endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             res_vld_o,
  output logic [WIDTH-1:0] result_o,
  output logic [FLG_W-1:0] flags_o
);

  localparam int HALF = WIDTH / 2;

  logic             rst_meta_q;
  logic             rst_sync_q;

  alu_op_e          op_e;
  shift_kind_e      sh_kind;
  logic [WIDTH-1:0] as_sum;
  logic             as_c;
  logic             as_v;
  logic [WIDTH-1:0] sh_res;
  logic             sh_c;
  logic             sh_v;
  logic [WIDTH-1:0] mul_prod;

  logic [WIDTH-1:0] result_d;
  logic [FLG_W-1:0] flags_d;
  logic             c_d;
  logic             v_d;

  logic             res_vld_q;
  logic [WIDTH-1:0] result_q;
  logic [FLG_W-1:0] flags_q;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign op_e = alu_op_e'(op_i);

  always_comb begin
    case (op_e)
      OP_LSR:  sh_kind = SH_LSR;
      OP_LSL:  sh_kind = SH_LSL;
      OP_ASR:  sh_kind = SH_ASR;
      default: sh_kind = SH_ROL;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a     (a_i),
    .b     (b_i),
    .sub   (op_e == OP_SUB),
    .sum   (as_sum),
    .carry (as_c),
    .ovf   (as_v)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .a     (a_i),
    .amt   (b_i),
    .kind  (sh_kind),
    .res   (sh_res),
    .carry (sh_c),
    .ovf   (sh_v)
  );

  alu_multiplier #(.WIDTH(WIDTH)) u_mul (
    .a_lo        (a_i[HALF-1:0]),
    .b_lo        (b_i[HALF-1:0]),
    .signed_mode (op_e == OP_MPYS),
    .prod        (mul_prod)
  );

  // next-state
  always_comb begin
    case (op_e)
      OP_ADD, OP_SUB: begin
        result_d = as_sum;
        c_d      = as_c;
        v_d      = as_v;
      end
      OP_LSR, OP_LSL, OP_ASR: begin
        result_d = sh_res;
        c_d      = sh_c;
        v_d      = sh_v;
      end
      OP_ROL: begin
        result_d = sh_res;
        c_d      = 1'b0;
        v_d      = 1'b0;
      end
      default: begin
        result_d = mul_prod;
        c_d      = 1'b0;
        v_d      = 1'b0;
      end
    endcase
    flags_d        = '0;
    flags_d[FLG_Z] = (result_d == '0);
    flags_d[FLG_C] = c_d;
    flags_d[FLG_N] = result_d[WIDTH-1];
    flags_d[FLG_V] = v_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      res_vld_q <= 1'b0;
      result_q  <= '0;
      flags_q   <= '0;
    end else begin
      res_vld_q <= valid_i;
      if (valid_i) begin
        result_q <= result_d;
        flags_q  <= flags_d;
      end
    end
  end

  assign res_vld_o = res_vld_q;
  assign result_o  = result_q;
  assign flags_o   = flags_q;

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             res_vld_o,
  input logic [WIDTH-1:0] result_o,
  input logic [FLG_W-1:0] flags_o
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> res_vld_o); // R1

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !res_vld_o); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(result_o) && $stable(flags_o))); // R1

  AST_ZERO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> ((flags_o[FLG_Z] == (result_o == '0)) && (flags_o[FLG_N] == result_o[WIDTH-1]))); // R2

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_ADD) |=> (result_o == $past(a_i) + $past(b_i))); // R3

  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_SUB) |=> (result_o == $past(a_i) - $past(b_i))); // R4

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_SUB) |=> (flags_o[FLG_C] == ($past(a_i) < $past(b_i)))); // R4

  AST_SHIFT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i >= OP_LSR && op_i <= OP_ROL && b_i == '0)
      |=> (result_o == $past(a_i) && !flags_o[FLG_C] && !flags_o[FLG_V])); // R5

  AST_ASR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_ASR) |=> !flags_o[FLG_V]); // R8

  AST_LOGIC_SHIFT_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == OP_LSR || op_i == OP_LSL))
      |=> (flags_o[FLG_V] == (result_o[WIDTH-1] != $past(a_i[WIDTH-1])))); // R9

  AST_ROL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_ROL) |=> (!flags_o[FLG_C] && !flags_o[FLG_V])); // R10

  AST_MPYU_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_MPYU) |=> (!flags_o[FLG_C] && !flags_o[FLG_V])); // R11

  AST_MPYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_MPYS) |=> (!flags_o[FLG_C] && !flags_o[FLG_V])); // R12

endmodule

bind alu_flags_core alu_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_q),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .res_vld_o (res_vld_o),
  .result_o  (result_o),
  .flags_o   (flags_o)
);

// File: tb/alu_flags_core_bench.sv
`timescale 1ns/1ps
module alu_flags_core_bench;

  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [31:0] a_i;
  logic [31:0] b_i;
  logic        res_vld_o;
  logic [31:0] result_o;
  logic [3:0]  flags_o;

  int n_chk;
  int n_bad;

  alu_flags_core u_alu_flags_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .res_vld_o (res_vld_o),
    .result_o  (result_o),
    .flags_o   (flags_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // one operation; inputs driven on a falling edge, outputs read one clock later
  task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp_r, input logic [3:0] exp_f);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    valid_i = 1'b0;
    check({tag, " vld"}, {31'd0, res_vld_o}, 32'd1);
    check({tag, " result"}, result_o, exp_r);
    check({tag, " flags"}, {28'd0, flags_o}, {28'd0, exp_f});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R13 reset vld", {31'd0, res_vld_o}, 32'd0);
    check("R13 reset result", result_o, 32'd0);
    check("R13 reset flags", {28'd0, flags_o}, 32'd0);
  endtask

  task automatic t_add();
    run_op("R3 add small", 3'd0, 32'd5, 32'd7, 32'd12, 4'h0);
    run_op("R3 add ovf", 3'd0, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 4'hC);
    run_op("R3 add carry", 3'd0, 32'hFFFF_FFFF, 32'd1, 32'd0, 4'h3);
  endtask

  task automatic t_sub();
    run_op("R4 sub ovf", 3'd1, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 4'h8);
    run_op("R4 sub borrow", 3'd1, 32'd0, 32'd1, 32'hFFFF_FFFF, 4'h6);
    run_op("R4 sub zero", 3'd1, 32'd9, 32'd9, 32'd0, 4'h1);
  endtask

  task automatic t_shift_zero();
    run_op("R5 lsr by 0", 3'd2, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 4'h4);
    run_op("R5 asr by 0", 3'd4, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 4'h4);
    run_op("R5 lsl by 0", 3'd3, 32'h8000_0000, 32'd0, 32'h8000_0000, 4'h4);
  endtask

  task automatic t_lsr();
    run_op("R6 R9 lsr 1 ones", 3'd2, 32'hFFFF_FFFF, 32'd1, 32'h7FFF_FFFF, 4'hA);
    run_op("R6 lsr zero by 1", 3'd2, 32'd0, 32'd1, 32'd0, 4'h1);
    run_op("R6 lsr by 32", 3'd2, 32'hFFFF_FFFF, 32'd32, 32'd0, 4'hB);
    run_op("R6 lsr by 40", 3'd2, 32'hFFFF_FFFF, 32'd40, 32'd0, 4'h9);
    run_op("R9 lsr sign", 3'd2, 32'h8000_0000, 32'd1, 32'h4000_0000, 4'h8);
  endtask

  task automatic t_lsl();
    run_op("R7 lsl 0x35 by 8", 3'd3, 32'h35, 32'd8, 32'h3500, 4'h0);
    run_op("R9 lsl to neg", 3'd3, 32'h4000_0000, 32'd1, 32'h8000_0000, 4'hC);
    run_op("R9 lsl from neg", 3'd3, 32'h8000_0000, 32'd1, 32'd0, 4'hB);
    run_op("R7 lsl by 32", 3'd3, 32'd1, 32'd32, 32'd0, 4'h3);
    run_op("R7 lsl by 33", 3'd3, 32'hFFFF_FFFF, 32'd33, 32'd0, 4'h9);
  endtask

  task automatic t_asr();
    run_op("R8 asr by 32", 3'd4, 32'hFFFF_FFFF, 32'd32, 32'hFFFF_FFFF, 4'h6);
    run_op("R8 asr neg by 4", 3'd4, 32'h8000_0000, 32'd4, 32'hF800_0000, 4'h4);
    run_op("R8 asr carry", 3'd4, 32'h0000_000F, 32'd2, 32'd3, 4'h2);
    run_op("R8 asr pos by 50", 3'd4, 32'h4000_0000, 32'd50, 32'd0, 4'h1);
  endtask

  task automatic t_rol();
    run_op("R10 rol 1 by 31", 3'd5, 32'd1, 32'd31, 32'h8000_0000, 4'h4);
    run_op("R10 rol by 33", 3'd5, 32'h8000_0001, 32'd33, 32'd3, 4'h0);
  endtask

  task automatic t_mpyu();
    run_op("R11 mpyu ffff", 3'd6, 32'hABCD_FFFF, 32'h1234_FFFF, 32'hFFFE_0001, 4'h4);
    run_op("R11 mpyu 23171", 3'd6, 32'd23171, 32'd23171, 32'd536895241, 4'h0);
  endtask

  task automatic t_mpys();
    run_op("R12 mpys 8000", 3'd7, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 4'h0);
    run_op("R12 mpys mixed", 3'd7, 32'h0000_8001, 32'h0000_7FFF, 32'hC000_FFFF, 4'h4);
    run_op("R12 mpys upper ignored", 3'd7, 32'h1234_0000, 32'hFFFF_0003, 32'd0, 4'h1);
  endtask

  // R1: pulse width, hold while idle, back-to-back operations
  task automatic t_timing();
    run_op("R1 seed", 3'd0, 32'd100, 32'd23, 32'd123, 4'h0);
    @(negedge clk);
    check("R1 vld drops", {31'd0, res_vld_o}, 32'd0);
    op_i = 3'd1; a_i = 32'd0; b_i = 32'd1;
    @(negedge clk);
    check("R1 hold result", result_o, 32'd123);
    check("R1 hold flags", {28'd0, flags_o}, 32'd0);
    valid_i = 1'b1; op_i = 3'd0; a_i = 32'd1; b_i = 32'd2;
    @(negedge clk);
    op_i = 3'd1; a_i = 32'd2; b_i = 32'd2;
    check("R1 b2b first", result_o, 32'd3);
    check("R1 b2b vld", {31'd0, res_vld_o}, 32'd1);
    @(negedge clk);
    valid_i = 1'b0;
    check("R1 b2b second", result_o, 32'd0);
    check("R1 b2b flags", {28'd0, flags_o}, 32'd1);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    valid_i = 1'b1; op_i = 3'd0; a_i = 32'hFFFF_FFFF; b_i = 32'd0;
    @(negedge clk);
    valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R13 mid reset result", result_o, 32'd0);
    check("R13 mid reset flags", {28'd0, flags_o}, 32'd0);
    check("R13 mid reset vld", {31'd0, res_vld_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; valid_i = 1'b0; op_i = 3'd0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_add();
    t_sub();
    t_shift_zero();
    t_lsr();
    t_lsl();
    t_asr();
    t_rol();
    t_mpyu();
    t_mpys();
    t_timing();
    t_reset_mid();
    run_op("R3 after reset", 3'd0, 32'd1, 32'd1, 32'd2, 4'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule